// File: doc/BRIEF.md
# Time-Slot Switch Processor Access Decoder

This block sits between a host processor bus and the memories of a time-slot switch. It decodes a 6-bit register address and holds an 8-bit page register. From these it produces read and write strobes and an 8-bit memory address for three arrays: the data memory, connection memory low and connection memory high. The memory address combines a 3-bit stream number with a 5-bit channel number. The block also selects which memory's read data goes back onto the bus. The host bus is synchronous. An access is a cycle in which `cs_i` is high together with `rd_i` or `wr_i`.

Addressing is indirect. The page register picks one of the three memories and one of eight streams. The five low address lines then pick one of the 32 channels in that stream. When the address MSB is low, the access goes to the page register or to an empty hole instead of a memory. The page register has a split setting. When split is on, every read comes from the data memory and every write goes to connection memory low. This lets a host watch incoming samples while it rewrites message bytes, without reloading the page register between the two operations.

All strobes, the memory address and the read data are combinational from the bus inputs and the page register. The page register loads on the clock edge that ends a write cycle. Its message-enable bit is exported to the switching datapath.

Top module: `tsw_cpu_port`

## Requirements
- R1: After reset the page register is 0x00. A read with addr[5]=0 and addr[1:0]=00 returns the full 8-bit page register on `rdata_o`, whatever the value of addr[4:2].
- R2: A write to the page register address loads all 8 bits of `wdata_i` at that clock edge. A page-register access asserts no memory strobe.
- R3: `msg_en_o` equals page bit 6 and changes only after a page-register write.
- R4: `mem_addr_o` is always {page[2:0], addr[4:0]}, which is {stream, channel}. `mem_wdata_o` is always `wdata_i`.
- R5: With split off and addr[5]=1, a read uses page bits 4:3 as the memory select. The value 01 pulses `dm_rd_o`, 10 pulses `cml_rd_o` and 11 pulses `cmh_rd_o`. `rdata_o` returns the matching read-data input.
- R6: Memory select 00 with split off is an empty selection. A read asserts no strobe and returns 0x00, and a write asserts no strobe.
- R7: The data memory is read-only. A write with split off and memory select 01 asserts no write strobe.
- R8: With page bit 7 (split) set and addr[5]=1, a read always pulses `dm_rd_o` and a write always pulses `cml_wr_o`, whatever the memory select.
- R9: If addr[5]=0 and addr[1:0] is not 00, a read returns 0x00, no strobe is asserted, and a write leaves the page register unchanged.
- R10: A cycle with both `rd_i` and `wr_i` high is a write only. If `cs_i` is low or no read is in progress, `rdata_o` is 0x00 and every read strobe is low. If `cs_i` is low, no write strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 6 | Register address; bit 5 selects memory space |
| wdata_i | input | 8 | Write data from host |
| rdata_o | output | 8 | Read data to host |
| msg_en_o | output | 1 | Message-enable to switching datapath |
| mem_addr_o | output | 8 | {stream, channel} memory address |
| mem_wdata_o | output | 8 | Write data to connection memories |
| dm_rd_o | output | 1 | Data memory read strobe |
| cml_rd_o | output | 1 | Connection memory low read strobe |
| cmh_rd_o | output | 1 | Connection memory high read strobe |
| cml_wr_o | output | 1 | Connection memory low write strobe |
| cmh_wr_o | output | 1 | Connection memory high write strobe |
| dm_rdata_i | input | 8 | Data memory read data |
| cml_rdata_i | input | 8 | Connection memory low read data |
| cmh_rdata_i | input | 8 | Connection memory high read data |

## Verification
The page register is the only state in the block. If it holds a wrong value, the fault shows at the ports in the very next cycle. A page-register read returns the wrong byte, `msg_en_o` has the wrong level, or `mem_addr_o` carries the wrong stream number. A wrong stored select or split bit sends the next memory access to the wrong strobe. The bench sweeps every page value through every address, with reads, writes, combined read-and-write cycles and deselected cycles. Because of this, any corrupted page bit or decode path is caught within one access.

// File: rtl/tsw_cpu_pkg.sv
package tsw_cpu_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_DM   = 2'b01,
    SEL_CML  = 2'b10,
    SEL_CMH  = 2'b11
  } mem_sel_e;

  typedef struct packed {
    logic dm_rd;
    logic cml_rd;
    logic cmh_rd;
    logic cml_wr;
    logic cmh_wr;
  } mem_strb_t;

  localparam int SPLIT_BIT = 7;
  localparam int MSG_BIT   = 6;

  // Route a memory-space access to exactly one array, or none.
  function automatic mem_strb_t route_access(logic split, mem_sel_e sel,
                                             logic rd, logic wr);
    mem_strb_t s;
    s = '0;
    if (rd) begin
      if (split) s.dm_rd = 1'b1;
      else begin
        s.dm_rd  = (sel == SEL_DM);
        s.cml_rd = (sel == SEL_CML);
        s.cmh_rd = (sel == SEL_CMH);
      end
    end
    if (wr) begin
      if (split) s.cml_wr = 1'b1;
      else begin
        s.cml_wr = (sel == SEL_CML);
        s.cmh_wr = (sel == SEL_CMH);
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/tsw_addr_decode.sv
module tsw_addr_decode #(
  parameter int ADDR_W = 6
) (
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              page_rd_o,
  output logic              page_wr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              hole_acc_o
);
  logic rd_eff, wr_eff, mem_space, page_slot;

  assign rd_eff    = cs_i & rd_i & ~wr_i;
  assign wr_eff    = cs_i & wr_i;
  assign mem_space = addr_i[ADDR_W-1];
  assign page_slot = ~mem_space & ~addr_i[1] & ~addr_i[0];

  assign page_rd_o  = rd_eff & page_slot;
  assign page_wr_o  = wr_eff & page_slot;
  assign mem_rd_o   = rd_eff & mem_space;
  assign mem_wr_o   = wr_eff & mem_space;
  assign hole_acc_o = (rd_eff | wr_eff) & ~mem_space & ~page_slot;
endmodule

// File: rtl/tsw_page_reg.sv
module tsw_page_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/tsw_rdata_mux.sv
module tsw_rdata_mux #(
  parameter int DATA_W = 8
) (
  input  logic              page_rd_i,
  input  logic              dm_rd_i,
  input  logic              cml_rd_i,
  input  logic              cmh_rd_i,
  input  logic [DATA_W-1:0] page_i,
  input  logic [DATA_W-1:0] dm_i,
  input  logic [DATA_W-1:0] cml_i,
  input  logic [DATA_W-1:0] cmh_i,
  output logic [DATA_W-1:0] rdata_o
);
  // AND-OR select; sources are mutually exclusive.
  assign rdata_o = ({DATA_W{page_rd_i}} & page_i)
                 | ({DATA_W{dm_rd_i}}   & dm_i)
                 | ({DATA_W{cml_rd_i}}  & cml_i)
                 | ({DATA_W{cmh_rd_i}}  & cmh_i);
endmodule

// File: rtl/tsw_cpu_port.sv
module tsw_cpu_port #(
  parameter int CHAN_W = 5,
  parameter int STRM_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic [CHAN_W:0]            addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       msg_en_o,
  output logic [STRM_W+CHAN_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]          mem_wdata_o,
  output logic                       dm_rd_o,
  output logic                       cml_rd_o,
  output logic                       cmh_rd_o,
  output logic                       cml_wr_o,
  output logic                       cmh_wr_o,
  input  logic [DATA_W-1:0]          dm_rdata_i,
  input  logic [DATA_W-1:0]          cml_rdata_i,
  input  logic [DATA_W-1:0]          cmh_rdata_i
);
  import tsw_cpu_pkg::*;

  localparam int ADDR_W = CHAN_W + 1;
  localparam int SEL_LO = STRM_W;

  // Named internal events for the checker.
  logic              page_rd_ev, page_wr_ev, mem_rd_ev, mem_wr_ev, hole_ev;
  logic [DATA_W-1:0] page_q;
  mem_sel_e          sel;
  logic              split;
  mem_strb_t         strb;

  tsw_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs_i      (cs_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .page_rd_o (page_rd_ev),
    .page_wr_o (page_wr_ev),
    .mem_rd_o  (mem_rd_ev),
    .mem_wr_o  (mem_wr_ev),
    .hole_acc_o(hole_ev)
  );

  tsw_page_reg #(.DATA_W(DATA_W)) u_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (page_wr_ev),
    .wdata_i(wdata_i),
    .q_o    (page_q)
  );

  assign split = page_q[SPLIT_BIT];
  assign sel   = mem_sel_e'(page_q[SEL_LO+1:SEL_LO]);
  assign strb  = route_access(split, sel, mem_rd_ev, mem_wr_ev);

  assign dm_rd_o     = strb.dm_rd;
  assign cml_rd_o    = strb.cml_rd;
  assign cmh_rd_o    = strb.cmh_rd;
  assign cml_wr_o    = strb.cml_wr;
  assign cmh_wr_o    = strb.cmh_wr;
  assign msg_en_o    = page_q[MSG_BIT];
  assign mem_addr_o  = {page_q[STRM_W-1:0], addr_i[CHAN_W-1:0]};
  assign mem_wdata_o = wdata_i;

  tsw_rdata_mux #(.DATA_W(DATA_W)) u_mux (
    .page_rd_i(page_rd_ev),
    .dm_rd_i  (strb.dm_rd),
    .cml_rd_i (strb.cml_rd),
    .cmh_rd_i (strb.cmh_rd),
    .page_i   (page_q),
    .dm_i     (dm_rdata_i),
    .cml_i    (cml_rdata_i),
    .cmh_i    (cmh_rdata_i),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/tsw_cpu_port_chk.sv
module tsw_cpu_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [5:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       msg_en_o,
  input logic [7:0] mem_addr_o,
  input logic       dm_rd_o,
  input logic       cml_rd_o,
  input logic       cmh_rd_o,
  input logic       cml_wr_o,
  input logic       cmh_wr_o,
  input logic       page_wr_ev,
  input logic       hole_ev,
  input logic [7:0] page_q
);
  p_rd_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dm_rd_o, cml_rd_o, cmh_rd_o, cml_wr_o, cmh_wr_o}));

  p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr_ev |=> page_q == $past(wdata_i));

  p_msg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !page_wr_ev |=> $stable(msg_en_o));

  p_chan_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_o[4:0] == addr_i[4:0]);

  p_dm_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && wr_i && addr_i[5] && !page_q[7] && page_q[4:3] == 2'b01)
      |-> !cml_wr_o && !cmh_wr_o);

  p_split_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && wr_i && addr_i[5] && page_q[7]) |-> cml_wr_o);

  p_hole_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hole_ev |-> rdata_o == 8'h00 && !page_wr_ev &&
                !(dm_rd_o | cml_rd_o | cmh_rd_o | cml_wr_o | cmh_wr_o));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_i && rd_i && !wr_i) |-> rdata_o == 8'h00 &&
                                 !(dm_rd_o | cml_rd_o | cmh_rd_o));
endmodule

bind tsw_cpu_port tsw_cpu_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_i      (cs_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .msg_en_o  (msg_en_o),
  .mem_addr_o(mem_addr_o),
  .dm_rd_o   (dm_rd_o),
  .cml_rd_o  (cml_rd_o),
  .cmh_rd_o  (cmh_rd_o),
  .cml_wr_o  (cml_wr_o),
  .cmh_wr_o  (cmh_wr_o),
  .page_wr_ev(page_wr_ev),
  .hole_ev   (hole_ev),
  .page_q    (page_q)
);

// File: tb/tsw_cpu_port_tb.sv
module tsw_cpu_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [5:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, mem_addr_o, mem_wdata_o;
  logic       msg_en_o, dm_rd_o, cml_rd_o, cmh_rd_o, cml_wr_o, cmh_wr_o;
  logic [7:0] dm_rdata_i, cml_rdata_i, cmh_rdata_i;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // Distinct memory contents: tag bits 7:6 name the array.
  assign dm_rdata_i  = {2'b01, addr_i};
  assign cml_rdata_i = {2'b10, addr_i};
  assign cmh_rdata_i = {2'b11, addr_i};

  tsw_cpu_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .msg_en_o(msg_en_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .dm_rd_o(dm_rd_o), .cml_rd_o(cml_rd_o), .cmh_rd_o(cmh_rd_o),
    .cml_wr_o(cml_wr_o), .cmh_wr_o(cmh_wr_o),
    .dm_rdata_i(dm_rdata_i), .cml_rdata_i(cml_rdata_i),
    .cmh_rdata_i(cmh_rdata_i)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (addr=%h page-op)", req, act, exp, addr_i);
    end
  endtask

  task automatic page_write(logic [7:0] v);
    @(negedge clk);
    cs_i = 1; wr_i = 1; rd_i = 0; addr_i = 6'b000000; wdata_i = v;
    @(negedge clk);
    cs_i = 0; wr_i = 0;
  endtask

  task automatic page_read_check(string req, logic [7:0] exp, logic [2:0] hi);
    @(negedge clk);
    cs_i = 1; rd_i = 1; wr_i = 0; addr_i = {1'b0, hi, 2'b00};
    #1 check(req, rdata_o, exp);
    @(negedge clk);
    cs_i = 0; rd_i = 0;
  endtask

  // Expected port vector: {strobes(5), rdata, mem_addr, mem_wdata}.
  function automatic logic [28:0] expect_vec(logic [7:0] pg, logic [5:0] a,
                                             int op, logic [7:0] wd);
    logic       is_rd, is_wr;
    logic [4:0] s;
    logic [7:0] rd;
    int         dst;
    is_rd = (op == 0);
    is_wr = (op == 1) || (op == 2);
    s = 5'b0; rd = 8'h00;
    if (a[5]) begin
      if (is_rd) begin
        dst = pg[7] ? 1 : int'(pg[4:3]);
        case (dst)
          1: begin s[4] = 1; rd = {2'b01, a}; end
          2: begin s[3] = 1; rd = {2'b10, a}; end
          3: begin s[2] = 1; rd = {2'b11, a}; end
          default: ;
        endcase
      end
      if (is_wr) begin
        dst = pg[7] ? 2 : int'(pg[4:3]);
        if (dst == 2) s[1] = 1;
        if (dst == 3) s[0] = 1;
      end
    end else if (is_rd && a[1:0] == 2'b00) begin
      rd = pg;
    end
    return {s, rd, pg[2:0], a[4:0], wd};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", rdata_o, 8'h00);
    check("R3", msg_en_o, 1'b0);
    rst_n = 1'b1;
    page_read_check("R1", 8'h00, 3'b101);

    for (int k = 0; k < 256; k++) begin
      page_write(k[7:0]);
      // R2 readback with addr[4:2] varied, R1 don't-care bits
      page_read_check("R2", k[7:0], k[2:0]);
      #0 check("R3", msg_en_o, k[6]);
      // R9: hole write leaves page register intact
      @(negedge clk);
      cs_i = 1; wr_i = 1; addr_i = {1'b0, k[2:0], 2'b01 + k[1:0] % 3};
      wdata_i = ~k[7:0];
      @(negedge clk);
      cs_i = 0; wr_i = 0;
      page_read_check("R9", k[7:0], 3'b000);
      // Sweep every address with read, write, read+write, deselected.
      for (int a = 0; a < 64; a++) begin
        for (int op = 0; op < 4; op++) begin
          @(negedge clk);
          addr_i  = a[5:0];
          wdata_i = k[7:0];
          cs_i    = (op != 3);
          rd_i    = (op == 0) || (op == 2) || (op == 3);
          wr_i    = (op == 1) || (op == 2) || (op == 3);
          #1;
          if (a >= 32)
            check(k[7] ? "R8" : (k[4:3] == 2'b00 ? "R6" :
                                 (k[4:3] == 2'b01 && op != 0 ? "R7" : "R5")),
                  {3'b0, dm_rd_o, cml_rd_o, cmh_rd_o, cml_wr_o, cmh_wr_o,
                   rdata_o, mem_addr_o, mem_wdata_o},
                  {3'b0, expect_vec(k[7:0], a[5:0], op, k[7:0])});
          else
            check(op >= 2 ? "R10" : (a[1:0] != 0 ? "R9" : "R2"),
                  {3'b0, dm_rd_o, cml_rd_o, cmh_rd_o, cml_wr_o, cmh_wr_o,
                   rdata_o, mem_addr_o, mem_wdata_o},
                  {3'b0, expect_vec(k[7:0], a[5:0], op, k[7:0])});
        end
      end
      @(negedge clk);
      cs_i = 0; rd_i = 0; wr_i = 0;
      #1 check("R4", mem_addr_o[7:5], k[2:0]);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule